// File: doc/BRIEF.md
# Two-Byte Serial DAC Update Host

This block is a host-side serial master that sends one 16-bit sample to a DAC that takes its input one bit at a time. A one-cycle `start` request captures the sample. The block drives the serial clock, the data line and an active-low select line, and it raises `done` when the transfer ends. The sample goes out as two 8-bit bytes with no pause between them, high byte first, most significant bit first. The serial clock idles low and the slave samples data on each rising edge.

The select line also serves as the DAC load command. It falls before the first bit and stays low across both bytes. After the last clock pulse there is a settable quiet interval, and then the select line rises. That rising edge tells the DAC to move the whole word into its output register. Two inputs set the timing: the number of system cycles in each half bit period, and the number of half periods in the quiet interval. Both are captured when a transfer is accepted. A half period of about 1 MHz bit rate is the usual setting.

Top module: `spi16_dac_host`

## Requirements
- R1: After reset `sck` is 0, `cs_n` is 1 and `done` is 0.
- R2: A `start` pulse seen while idle drives `cs_n` low on the next clock edge. The first rising edge of `sck` follows one half period after that.
- R3: The bits sampled on the 16 rising edges of `sck`, taken in order, equal the `word` captured at `start`. Bits 15 down to 8 come first, then bits 7 down to 0.
- R4: `sck` idles low. `mosi` changes only together with a falling edge of `sck`, or at the accepting edge while `sck` is low, so it is stable across each rising edge.
- R5: Each frame has exactly 16 rising edges of `sck`. `sck` is high only while `cs_n` is low.
- R6: Each half period, high or low, lasts max(`half_period`,1) system cycles. That includes the setup interval between the fall of `cs_n` and the first rising edge.
- R7: `cs_n` rises max(`gap_halves`,1) half periods after the last falling edge of `sck`, and `sck` stays low throughout that interval.
- R8: `done` is high for exactly one cycle, the cycle after `cs_n` returns high, and is low at all other times.
- R9: A `start` pulse during a transfer is ignored. The frame in progress keeps its captured word and timing, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send `word` |
| word | input | 16 | Sample to send, captured at an accepted `start` |
| half_period | input | 8 | System cycles per half bit period (0 treated as 1) |
| gap_halves | input | 4 | Half periods between last clock and select rise (0 treated as 1) |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data, most significant bit first |
| cs_n | output | 1 | Active-low select; its rising edge loads the DAC |
| done | output | 1 | One-cycle pulse after the select line rises |

## Verification
The bench decodes the serial stream on the rising edges, rebuilds the word, and measures every half period and the quiet interval in system cycles. It tries all-zero, all-one and mid-scale boundary words, a divider and gap of zero, and random settings. A divider setting of zero that is not raised to one would produce a frame with no clock pulses or a hung frame. Swapping the byte or bit order would turn 0x8000 into 0x0080 or 0x0001. Changing data on the rising edge would shift the decoded word by one bit. The bench also sends a second request with a different word in the middle of a frame. A design that accepted it would corrupt the word or start an extra frame after `done`.

// File: rtl/spi16_pkg.sv
package spi16_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP,
    ST_FIN
  } host_state_e;
endpackage

// File: rtl/spi16_tick.sv
// Half-bit-period timer: restart captures the period, tick marks each expiry.
module spi16_tick #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic [HP_W-1:0] period_in,
  output logic            tick
);
  logic [HP_W-1:0] per_q, per_nxt;
  logic [HP_W-1:0] cnt_q, cnt_nxt;
  logic [HP_W-1:0] per_eff;

  always_comb begin
    per_eff = (period_in == '0) ? HP_W'(1) : period_in;
    tick    = run && !restart && (cnt_q == '0);
    per_nxt = per_q;
    cnt_nxt = cnt_q;
    if (restart) begin
      per_nxt = per_eff;
      cnt_nxt = per_eff - HP_W'(1);
    end else if (run) begin
      cnt_nxt = (cnt_q == '0) ? (per_q - HP_W'(1)) : (cnt_q - HP_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= HP_W'(1);
      cnt_q <= '0;
    end else begin
      per_q <= per_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/spi16_shift.sv
// Left-shifting data register; bit WORD_W-1 drives the serial line.
module spi16_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] din,
  output logic              msb
);
  logic [WORD_W-1:0] sr_q, sr_nxt;

  always_comb begin
    sr_nxt = sr_q;
    if (load)       sr_nxt = din;
    else if (shift) sr_nxt = {sr_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nxt;
  end

  assign msb = sr_q[WORD_W-1];
endmodule

// File: rtl/spi16_dac_host.sv
module spi16_dac_host
  import spi16_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int HP_W   = 8,
  parameter int GAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic [HP_W-1:0]   half_period,
  input  logic [GAP_W-1:0]  gap_halves,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              done
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  host_state_e      st_q, st_nxt;
  logic             sck_q, sck_nxt;
  logic             cs_q, cs_nxt;
  logic             done_q, done_nxt;
  logic [BIT_W-1:0] bit_q, bit_nxt;
  logic [GAP_W-1:0] gap_cnt_q, gap_cnt_nxt;
  logic [GAP_W-1:0] gap_lim_q, gap_lim_nxt;
  logic             restart, run, tick, load, shift;

  assign run = (st_q != ST_IDLE) && (st_q != ST_FIN);

  spi16_tick #(.HP_W(HP_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
    .period_in(half_period), .tick(tick)
  );

  spi16_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .din(word), .msb(mosi)
  );

  always_comb begin
    st_nxt      = st_q;
    sck_nxt     = sck_q;
    cs_nxt      = cs_q;
    done_nxt    = 1'b0;
    bit_nxt     = bit_q;
    gap_cnt_nxt = gap_cnt_q;
    gap_lim_nxt = gap_lim_q;
    restart     = 1'b0;
    load        = 1'b0;
    shift       = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          restart     = 1'b1;
          load        = 1'b1;
          cs_nxt      = 1'b0;
          sck_nxt     = 1'b0;
          bit_nxt     = '0;
          gap_cnt_nxt = '0;
          gap_lim_nxt = (gap_halves == '0) ? GAP_W'(1) : gap_halves;
          st_nxt      = ST_SETUP;
        end
      end
      ST_SETUP, ST_LOW: begin
        if (tick) begin
          sck_nxt = 1'b1;
          st_nxt  = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          sck_nxt = 1'b0;
          if (bit_q == LAST_BIT) begin
            gap_cnt_nxt = '0;
            st_nxt      = ST_GAP;
          end else begin
            shift   = 1'b1;
            bit_nxt = bit_q + BIT_W'(1);
            st_nxt  = ST_LOW;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gap_cnt_q == gap_lim_q - GAP_W'(1)) begin
            cs_nxt = 1'b1;
            st_nxt = ST_FIN;
          end else begin
            gap_cnt_nxt = gap_cnt_q + GAP_W'(1);
          end
        end
      end
      ST_FIN: begin
        done_nxt = 1'b1;
        st_nxt   = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      done_q    <= 1'b0;
      bit_q     <= '0;
      gap_cnt_q <= '0;
      gap_lim_q <= GAP_W'(1);
    end else begin
      st_q      <= st_nxt;
      sck_q     <= sck_nxt;
      cs_q      <= cs_nxt;
      done_q    <= done_nxt;
      bit_q     <= bit_nxt;
      gap_cnt_q <= gap_cnt_nxt;
      gap_lim_q <= gap_lim_nxt;
    end
  end

  assign sck  = sck_q;
  assign cs_n = cs_q;
  assign done = done_q;
endmodule

// File: rtl/spi16_dac_host_chk.sv
module spi16_dac_host_chk #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic mosi,
  input logic cs_n,
  input logic done
);
  localparam int CNT_W = $clog2(WORD_W) + 2;

  logic             sck_d, cs_d;
  logic [CNT_W-1:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      cs_d     <= 1'b1;
      rise_cnt <= '0;
    end else begin
      sck_d <= sck;
      cs_d  <= cs_n;
      if (!cs_n && cs_d)      rise_cnt <= '0;
      else if (sck && !sck_d) rise_cnt <= rise_cnt + CNT_W'(1);
    end
  end

  assert_clock_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  assert_edge_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == CNT_W'(WORD_W)));
  assert_data_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
  assert_data_while_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  assert_quiet_before_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sck && !$past(sck)));
  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> done);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(cs_n)));
endmodule

bind spi16_dac_host spi16_dac_host_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n), .done(done)
);

// File: tb/spi16_dac_host_tb.sv
module spi16_dac_host_tb;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] word;
  logic [7:0]  half_period;
  logic [3:0]  gap_halves;
  logic        sck, mosi, cs_n, done;

  int checks = 0;
  int errors = 0;

  spi16_dac_host u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word),
    .half_period(half_period), .gap_halves(gap_halves),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor state
  logic        p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0, done_exp = 1'b0;
  logic [15:0] cap = '0, fr_word = '0;
  int nrise = 0, fr_rise = 0, ph = 0, fr_gap = 0;
  int ph_err = 0, stab_err = 0, sel_err = 0, done_err = 0, frames = 0;
  int exp_hp = 1, exp_gap = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      ph++;
      if (done !== done_exp) done_err++;
      done_exp = 1'b0;
      if (sck && cs_n) sel_err++;
      if (!cs_n && p_cs) begin
        nrise = 0; cap = '0; ph = 0;
      end
      if (sck && !p_sck) begin
        nrise++;
        cap = {cap[14:0], mosi};
        if (mosi !== p_mosi) stab_err++;
        if (ph != exp_hp) ph_err++;
        ph = 0;
      end
      if (!sck && p_sck) begin
        if (ph != exp_hp) ph_err++;
        ph = 0;
      end
      if (sck && p_sck && (mosi !== p_mosi)) stab_err++;
      if (cs_n && !p_cs) begin
        fr_word = cap; fr_rise = nrise; fr_gap = ph;
        done_exp = 1'b1;
        frames++;
      end
      p_sck = sck; p_cs = cs_n; p_mosi = mosi;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [15:0] w, input logic [7:0] hp,
                           input logic [3:0] gp, input bit poke);
    int f0, t;
    exp_hp  = (hp == 0) ? 1 : int'(hp);
    exp_gap = (gp == 0) ? 1 : int'(gp);
    ph_err = 0; stab_err = 0; sel_err = 0; done_err = 0;
    @(negedge clk);
    word = w; half_period = hp; gap_halves = gp; start = 1'b1;
    f0 = frames;
    @(negedge clk);
    start = 1'b0;
    chk(cs_n == 1'b0, "R2 select low after start", int'(cs_n), 0);
    if (poke) begin
      repeat (5 * exp_hp) @(negedge clk);
      word = ~w; half_period = hp + 8'd3; gap_halves = gp + 4'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (frames == f0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    chk(frames == f0 + 1, "R8 frame completed", frames - f0, 1);
    chk(fr_word == w, "R3 word", int'(fr_word), int'(w));
    chk(fr_rise == 16, "R5 rising edges", fr_rise, 16);
    chk(sel_err == 0, "R5 clock only while selected", sel_err, 0);
    chk(stab_err == 0, "R4 data stable over rising edge", stab_err, 0);
    chk(ph_err == 0, "R6 half period length", ph_err, 0);
    chk(fr_gap == exp_gap * exp_hp, "R7 gap cycles", fr_gap, exp_gap * exp_hp);
    chk(done_err == 0, "R8 done timing", done_err, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(frames == f0 + 1 && cs_n == 1'b1, "R9 no extra frame", frames - f0, 1);
      chk(done_err == 0, "R9 no extra done", done_err, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; word = '0; half_period = 8'd1; gap_halves = 4'd1;
    repeat (3) @(negedge clk);
    chk(sck == 1'b0 && cs_n == 1'b1 && done == 1'b0, "R1 reset state",
        int'({sck, cs_n, done}), 3'b010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sck == 1'b0 && cs_n == 1'b1 && done == 1'b0, "R1 idle after reset",
        int'({sck, cs_n, done}), 3'b010);
    // directed corners
    run_frame(16'h0000, 8'd0, 4'd0, 1'b0);
    run_frame(16'hFFFF, 8'd1, 4'd1, 1'b0);
    run_frame(16'h8000, 8'd2, 4'd3, 1'b0);
    run_frame(16'h7FFF, 8'd3, 4'd2, 1'b0);
    run_frame(16'h0001, 8'd1, 4'd0, 1'b0);
    run_frame(16'hA55A, 8'd2, 4'd1, 1'b1);
    // constrained random
    for (int i = 0; i < 24; i++) begin
      run_frame(16'($urandom), 8'($urandom_range(0, 5)), 4'($urandom_range(0, 4)),
                ($urandom_range(0, 3) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule